// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block is a SIMD integer datapath that adds or subtracts two 128-bit packed vector operands lane by lane, clamping every lane to its representable range instead of letting it wrap. A control input picks the lane width (8, 16, 32 or 64 bits), another picks signed or unsigned arithmetic, and a third picks addition or subtraction. The operation can cover the whole register or only its lower half. Result bits above the active size are forced to zero.

The result is registered one cycle after an input strobe and is held until the next strobe. A sticky saturation flag records that some active lane was clamped since it was last cleared. Only a dedicated synchronous clear input lowers it. Software reads the flag after a batch of operations to learn whether any precision was lost.

Top module: `sat_vec_unit`

## Requirements
- R1: `laneSel` selects the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Lane k occupies bits [k*w +: w], and each lane is computed independently of its neighbours.
- R2: With `isSigned`=0, `isSub`=0 adds and `isSub`=1 subtracts (A minus B). A result below 0 becomes 0, and a result above 2^w-1 becomes all-ones.
- R3: With `isSigned`=1, lanes are two's complement. A result outside the range becomes -2^(w-1) when it is below that bound and 2^(w-1)-1 when it is above.
- R4: A lane whose exact result fits in its range outputs that exact result.
- R5: `fullSize`=1 processes all 128 bits. `fullSize`=0 processes only bits 63:0, outputs zero in bits 127:64, and lanes in the upper half cannot set the flag.
- R6: A strobed operation in which at least one active lane clamps sets `satFlag` to 1 in the next cycle.
- R7: `satFlag` falls only in the cycle after `clrSat`=1. When `clrSat` and a clamping operation occur in the same cycle, the flag reads 1 afterwards.
- R8: `resOut` and `resValid` update one clock after `inValid`=1. After a cycle without `inValid`, `resValid` is 0 and `resOut` keeps its previous value.
- R9: After reset, `resOut`=0, `resValid`=0 and `satFlag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| isSub | input | 1 | 1 = subtract, 0 = add |
| isSigned | input | 1 | 1 = signed lanes |
| laneSel | input | 2 | Lane width code |
| fullSize | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| opA | input | 128 | First operand |
| opB | input | 128 | Second operand |
| clrSat | input | 1 | Synchronous clear of the sticky flag |
| resOut | output | 128 | Registered clamped result |
| resValid | output | 1 | Result updated this cycle |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
Every width, signedness, direction and size combination is driven with lanes that hold zero, one, all-ones, the signed minimum and the signed maximum. Each lane receives a different pairing, so a defect in lane slicing or in selecting the width shows up as a mismatch in a single lane. Pairs that miss a limit by exactly one, such as maximum plus one or zero minus one, separate an off-by-one limit compare from a correct one. They also separate a signed clamp from an unsigned one. Directed sequences with saturation only in the upper half, together with sequences that clear the flag and clamp in the same cycle, separate correct tail masking and flag priority from wrong ones.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {LANE8 = 2'd0, LANE16 = 2'd1, LANE32 = 2'd2, LANE64 = 2'd3} lane_e;

  typedef struct packed {
    logic load;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         isSub,
  input  logic         isSigned,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int XW = W + 2;

  logic signed [XW-1:0] ax, bx, sx, hi, lo;

  always_comb begin
    ax = $signed({{2{isSigned & a[W-1]}}, a});
    bx = $signed({{2{isSigned & b[W-1]}}, b});
    sx = isSub ? (ax - bx) : (ax + bx);
    hi = isSigned ? $signed({3'b000, {(W-1){1'b1}}}) : $signed({2'b00, {W{1'b1}}});
    lo = isSigned ? $signed({3'b111, {(W-1){1'b0}}}) : '0;
    if (sx > hi) begin
      res = hi[W-1:0];
      sat = 1'b1;
    end else if (sx < lo) begin
      res = lo[W-1:0];
      sat = 1'b1;
    end else begin
      res = sx[W-1:0];
      sat = 1'b0;
    end
  end
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  input  logic    clrSat,
  output strobe_t st,
  output logic    resValid
);
  always_comb begin
    st.load  = inValid;
    st.clear = clrSat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= inValid;
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> resValid);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !resValid);
endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          st,
  input  logic             isSub,
  input  logic             isSigned,
  input  logic [1:0]       laneSel,
  input  logic             fullSize,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic [VEC_W-1:0] resQ,
  output logic             satQ
);
  localparam int NW   = 4;
  localparam int HALF = VEC_W / 2;

  logic [NW-1:0][VEC_W-1:0] widthRes;
  logic [NW-1:0]            widthSat;
  logic [VEC_W-1:0]         keepMask, nextRes;
  logic                     anySat;

  for (genvar g = 0; g < NW; g++) begin : gWidth
    localparam int LW = 8 << g;
    localparam int NL = VEC_W / LW;
    logic [NL-1:0]    laneSat;
    logic [NL-1:0]    actMask;
    logic [VEC_W-1:0] laneRes;
    for (genvar l = 0; l < NL; l++) begin : gLane
      sat_lane #(.W(LW)) uLane (
        .a        (opA[l*LW +: LW]),
        .b        (opB[l*LW +: LW]),
        .isSub    (isSub),
        .isSigned (isSigned),
        .res      (laneRes[l*LW +: LW]),
        .sat      (laneSat[l])
      );
    end
    assign actMask     = fullSize ? {NL{1'b1}} : {{(NL - NL/2){1'b0}}, {(NL/2){1'b1}}};
    assign widthRes[g] = laneRes;
    assign widthSat[g] = |(laneSat & actMask);
  end

  assign keepMask = fullSize ? {VEC_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign nextRes  = widthRes[laneSel] & keepMask;
  assign anySat   = widthSat[laneSel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resQ <= '0;
      satQ <= 1'b0;
    end else begin
      if (st.load) resQ <= nextRes;
      satQ <= (satQ & ~st.clear) | (st.load & anySat);
    end
  end

  // R7
  sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(satQ) |-> $past(st.clear));
  // R6
  sat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.load && anySat) |=> satQ);
  // R5
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.load && !fullSize) |=> (resQ[VEC_W-1:HALF] == '0));
  // R8
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st.load |=> $stable(resQ));
endmodule

// File: rtl/sat_vec_unit.sv
module sat_vec_unit
  import sat_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             isSub,
  input  logic             isSigned,
  input  logic [1:0]       laneSel,
  input  logic             fullSize,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic             clrSat,
  output logic [VEC_W-1:0] resOut,
  output logic             resValid,
  output logic             satFlag
);
  strobe_t st;

  sat_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .clrSat   (clrSat),
    .st       (st),
    .resValid (resValid)
  );

  sat_datapath #(.VEC_W(VEC_W)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .isSub    (isSub),
    .isSigned (isSigned),
    .laneSel  (laneSel),
    .fullSize (fullSize),
    .opA      (opA),
    .opB      (opB),
    .resQ     (resOut),
    .satQ     (satFlag)
  );
endmodule

// File: tb/sim_sat_vec_unit.sv
module sim_sat_vec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0, isSub = 1'b0, isSigned = 1'b0, fullSize = 1'b1, clrSat = 1'b0;
  logic [1:0]   laneSel = 2'd0;
  logic [127:0] opA = '0, opB = '0;
  logic [127:0] resOut;
  logic         resValid, satFlag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [127:0] mRes = '0;
  logic         mSat = 1'b0;
  logic         mValid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_vec_unit u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .isSub(isSub), .isSigned(isSigned),
    .laneSel(laneSel), .fullSize(fullSize), .opA(opA), .opB(opB), .clrSat(clrSat),
    .resOut(resOut), .resValid(resValid), .satFlag(satFlag)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void refOp(input logic [127:0] a, input logic [127:0] b, input logic sub,
                                input logic sgn, input int lw, input logic full,
                                output logic [127:0] r, output logic s);
    int nl;
    logic [127:0] lmask;
    nl = (full ? 128 : 64) / lw;
    lmask = (128'd1 << lw) - 128'd1;
    r = '0;
    s = 1'b0;
    for (int l = 0; l < nl; l++) begin
      logic signed [67:0] xa, xb, xs, hi, lo;
      xa = $signed(68'((a >> (l*lw)) & lmask));
      xb = $signed(68'((b >> (l*lw)) & lmask));
      if (sgn && xa[lw-1]) xa = xa - (68'sd1 <<< lw);
      if (sgn && xb[lw-1]) xb = xb - (68'sd1 <<< lw);
      xs = sub ? xa - xb : xa + xb;
      hi = sgn ? (68'sd1 <<< (lw-1)) - 68'sd1 : (68'sd1 <<< lw) - 68'sd1;
      lo = sgn ? -(68'sd1 <<< (lw-1)) : 68'sd0;
      if (xs > hi) begin xs = hi; s = 1'b1; end
      else if (xs < lo) begin xs = lo; s = 1'b1; end
      r = r | ((128'(xs) & lmask) << (l*lw));
    end
  endfunction

  // One clock: drive at a falling edge, update the model, compare at the next falling edge.
  task automatic step(input logic v, input logic clr, input logic sub, input logic sgn,
                      input logic [1:0] ls, input logic full, input logic [127:0] a,
                      input logic [127:0] b, input string resTag, input string satTag);
    logic [127:0] r;
    logic s;
    inValid = v; clrSat = clr; isSub = sub; isSigned = sgn;
    laneSel = ls; fullSize = full; opA = a; opB = b;
    if (clr) mSat = 1'b0;
    if (v) begin
      refOp(a, b, sub, sgn, 8 << ls, full, r, s);
      mRes = r;
      mSat = mSat | s;
    end
    mValid = v;
    @(negedge clk);
    chk(resOut == mRes, resTag, resOut, mRes);
    chk(satFlag == mSat, satTag, 128'(satFlag), 128'(mSat));
    chk(resValid == mValid, "R8", 128'(resValid), 128'(mValid));
  endtask

  function automatic logic [127:0] patVal(input int k, input int lw);
    logic [127:0] ones;
    ones = (128'd1 << lw) - 128'd1;
    case (k % 6)
      0: return 128'd0;
      1: return 128'd1;
      2: return ones;
      3: return 128'd1 << (lw-1);
      4: return (128'd1 << (lw-1)) - 128'd1;
      default: return 128'd2;
    endcase
  endfunction

  function automatic logic [127:0] fill(input int base, input int stride, input int lw);
    logic [127:0] v;
    v = '0;
    for (int l = 0; l < 128/lw; l++) v = v | (patVal(base + stride*l, lw) << (l*lw));
    return v;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(resOut == '0, "R9", resOut, '0);
    chk(resValid == 1'b0, "R9", 128'(resValid), 128'd0);
    chk(satFlag == 1'b0, "R9", 128'(satFlag), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 exact in-range results, 32-bit signed
    step(1, 0, 0, 1, 2'd2, 1, {32'd5, 32'hFFFF_FFFE, 32'd100, 32'd7},
         {32'd3, 32'd1, 32'hFFFF_FF9C, 32'd9}, "R4", "R6");
    chk(resOut == {32'd8, 32'hFFFF_FFFF, 32'd0, 32'd16}, "R4", resOut,
        {32'd8, 32'hFFFF_FFFF, 32'd0, 32'd16});
    // R8 idle cycle holds the result
    step(0, 0, 1, 0, 2'd0, 1, '1, '1, "R8", "R7");
    chk(resOut == {32'd8, 32'hFFFF_FFFF, 32'd0, 32'd16}, "R8", resOut,
        {32'd8, 32'hFFFF_FFFF, 32'd0, 32'd16});
    // R1 mixed 16-bit lanes: carries must not cross lanes
    step(1, 0, 0, 0, 2'd1, 1, {8{16'hFFFF}}, {8{16'h0001}}, "R1", "R6");
    chk(resOut == {8{16'hFFFF}}, "R1", resOut, {8{16'hFFFF}});
    // R7 sticky after non-saturating op, then clear
    step(1, 0, 0, 0, 2'd0, 1, '0, '0, "R4", "R7");
    chk(satFlag == 1'b1, "R7", 128'(satFlag), 128'd1);
    step(0, 1, 0, 0, 2'd0, 1, '0, '0, "R8", "R7");
    chk(satFlag == 1'b0, "R7", 128'(satFlag), 128'd0);
    // R7 clear together with a clamping op leaves flag set
    step(1, 1, 1, 0, 2'd3, 1, '0, {64'd0, 64'd1}, "R2", "R7");
    chk(satFlag == 1'b1, "R7", 128'(satFlag), 128'd1);
    step(0, 1, 0, 0, 2'd0, 1, '0, '0, "R8", "R7");
    // R5 saturation only in the upper half with a half-size op
    step(1, 0, 0, 0, 2'd0, 0, {{64{1'b1}}, 64'h0102_0304_0506_0708},
         {{8{8'h01}}, 64'h0101_0101_0101_0101}, "R5", "R5");
    chk(satFlag == 1'b0, "R5", 128'(satFlag), 128'd0);
    chk(resOut == {64'd0, 64'h0203_0405_0607_0809}, "R5", resOut,
        {64'd0, 64'h0203_0405_0607_0809});

    // Boundary sweep over all modes
    for (int ls = 0; ls < 4; ls++)
      for (int sg = 0; sg < 2; sg++)
        for (int sb = 0; sb < 2; sb++)
          for (int fs = 0; fs < 2; fs++)
            for (int i = 0; i < 6; i++)
              for (int j = 0; j < 6; j++)
                step(1, (i == 0 && j == 0), sb[0], sg[0], ls[1:0], fs[0],
                     fill(i, 1, 8 << ls), fill(j, 5, 8 << ls),
                     sg ? "R3" : "R2", fs ? "R6" : "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule